// File: doc/BRIEF.md
# Display Update Persistence Filter

This block sits between the result of a frequency-measurement counter and the register that feeds a static numeric display. Each time the timing sequencer issues its end-of-measurement strobe, the block compares the frozen count with the value now on the display, bit for bit. An exact match means the reading is unchanged. A mismatch is treated as evidence of a possible real change.

A persistence counter counts consecutive mismatching measurements and clears on any exact match. The display register takes the new count only when the number of consecutive mismatches reaches a programmable confirmation level. A reading that jitters by one count between two neighbouring values keeps resetting the counter, so it never reaches the display. The first measurement after reset is always shown, so the display never starts from a value that was never measured.

Top module: `dfilt_update_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `disp_o` reads zero and `disp_load_o` is low.
- R2: The first strobe after reset loads `count_i` into `disp_o`, whatever its value, including a value equal to the current display. `disp_load_o` is high for the single cycle after that strobe edge.
- R3: Without a strobe, `disp_o` keeps its value and `disp_load_o` stays low, whatever `count_i` does.
- R4: Each strobe whose `count_i` differs from `disp_o` in any bit adds one to the persistence count. The differing values need not be equal to one another. When that count reaches `confirm_n_i`, that strobe's `count_i` is loaded into `disp_o` and `disp_load_o` pulses.
- R5: A strobe whose `count_i` equals `disp_o` exactly clears the persistence count and leaves the display unchanged.
- R6: With `confirm_n_i` of 2 or more, a count that alternates strobe by strobe between the displayed value and a neighbouring value never updates the display.
- R7: With `confirm_n_i` of 0 or 1, the first mismatching strobe updates the display at once.
- R8: A display update clears the persistence count in the same cycle, so the next change again needs `confirm_n_i` consecutive mismatches.
- R9: The persistence count never wraps. If `confirm_n_i` is lowered below the count already reached, the next mismatching strobe updates the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_i | input | 1 | End-of-measurement latch strobe, one cycle per measurement |
| count_i | input | DATA_W | Count frozen at the end of the gate period |
| confirm_n_i | input | CONF_W | Consecutive mismatches needed before the display updates |
| disp_o | output | DATA_W | Displayed value |
| disp_load_o | output | 1 | Pulses for one cycle when `disp_o` has just been reloaded |

## Verification
The bench alternates a count between the displayed value and its neighbour. A design that does not clear the counter on a match would, in that case, step the display after a few measurements. It checks that a run of mismatches made of different values still confirms the change, and that the last value is the one shown. It also checks that a second change needs the full run again, which an update that leaves the counter set would shorten. Further cases are the zero and one threshold settings, lowering the threshold while a count is pending, and the first strobe after reset carrying a value equal to zero. A design that only loads on a difference would skip that first load.

// File: rtl/dfilt_pkg.sv
// Package: shared types for the display update persistence filter.
// Assumes nothing beyond standard SystemVerilog.
package dfilt_pkg;
    // What a strobe did to the persistence state.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,   // no strobe this cycle
        ACT_MATCH = 2'd1,   // count equal to display, counter cleared
        ACT_COUNT = 2'd2,   // mismatch, counter advanced
        ACT_LOAD  = 2'd3    // display reloaded
    } dfilt_act_e;
endpackage

// File: rtl/dfilt_compare.sv
// Module: bitwise comparison of the new count with the displayed value.
// Assumes both operands are stable in the cycle the strobe is sampled.
module dfilt_compare #(
    parameter int DATA_W = 24
) (
    input  logic [DATA_W-1:0] count_i,
    input  logic [DATA_W-1:0] disp_i,
    output logic              differ_o
);
    logic [DATA_W-1:0] diff_bits;

    // Per-bit difference reduced to a single mismatch flag.
    always_comb begin
        diff_bits = count_i ^ disp_i;
        differ_o  = |diff_bits;
    end
endmodule

// File: rtl/dfilt_persist.sv
// Module: persistence counter that decides when the display may reload.
// Assumes strobe_i is a single-cycle pulse and primed_i tells whether
// the display has held a measured value since reset.
module dfilt_persist
    import dfilt_pkg::*;
#(
    parameter int CONF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              differ_i,
    input  logic              primed_i,
    input  logic [CONF_W-1:0] confirm_n_i,
    output logic              fire_o,
    output dfilt_act_e        act_o
);
    logic [CONF_W-1:0] cnt_q;
    logic [CONF_W:0]   cnt_inc;
    logic              reach;
    logic [CONF_W-1:0] cnt_sat;

    // Next count and the confirmation test against the threshold.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{CONF_W{1'b0}}, 1'b1};
        reach   = cnt_inc >= {1'b0, confirm_n_i};
        cnt_sat = (&cnt_q) ? cnt_q : cnt_inc[CONF_W-1:0];
    end

    // Classify the strobe: first load, confirmed load, advance or clear.
    always_comb begin
        if (!strobe_i)                  act_o = ACT_IDLE;
        else if (!primed_i)             act_o = ACT_LOAD;
        else if (!differ_i)             act_o = ACT_MATCH;
        else if (reach)                 act_o = ACT_LOAD;
        else                            act_o = ACT_COUNT;
        fire_o = (act_o == ACT_LOAD);
    end

    // Counter register: advance on mismatch, clear on match or load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (act_o)
                ACT_COUNT: cnt_q <= cnt_sat;
                ACT_MATCH,
                ACT_LOAD:  cnt_q <= '0;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && primed_i && !differ_i) |=> (cnt_q == '0)); // R5

    AST_MISMATCH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && primed_i && differ_i && !fire_o) |=> (cnt_q == CONF_W'($past(cnt_q) + 1'b1))); // R4

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (cnt_q == '0)); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && primed_i && differ_i && (cnt_q >= confirm_n_i)) |-> fire_o); // R9
endmodule

// File: rtl/dfilt_display.sv
// Module: display register with its load pulse and a primed flag.
// Assumes fire_i is asserted for one cycle per accepted measurement.
module dfilt_display #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] disp_o,
    output logic              load_o,
    output logic              primed_o
);
    // Display value, load pulse and first-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_o   <= '0;
            load_o   <= 1'b0;
            primed_o <= 1'b0;
        end else begin
            load_o <= fire_i;
            if (fire_i) begin
                disp_o   <= count_i;
                primed_o <= 1'b1;
            end
        end
    end

    AST_HOLD_WITHOUT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fire_i)) |-> $stable(disp_o)); // R3
endmodule

// File: rtl/dfilt_update_filter.sv
// Module: top of the display update persistence filter.
// Wires the comparator, the persistence counter and the display register.
// Assumes count_i is frozen while strobe_i is high and that strobe_i is a
// single-cycle pulse from the measurement sequencer.
module dfilt_update_filter
    import dfilt_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CONF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic [CONF_W-1:0] confirm_n_i,
    output logic [DATA_W-1:0] disp_o,
    output logic              disp_load_o
);
    logic       differ;
    logic       primed;
    logic       fire;
    dfilt_act_e act;

    dfilt_compare #(.DATA_W(DATA_W)) cmp_i (
        .count_i (count_i),
        .disp_i  (disp_o),
        .differ_o(differ)
    );

    dfilt_persist #(.CONF_W(CONF_W)) pers_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (strobe_i),
        .differ_i   (differ),
        .primed_i   (primed),
        .confirm_n_i(confirm_n_i),
        .fire_o     (fire),
        .act_o      (act)
    );

    dfilt_display #(.DATA_W(DATA_W)) disp_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .count_i (count_i),
        .disp_o  (disp_o),
        .load_o  (disp_load_o),
        .primed_o(primed)
    );

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !primed) |=> disp_load_o); // R2

    AST_LOAD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_load_o |-> ($past(rst_n) && $past(strobe_i))); // R3

    AST_LOAD_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        disp_load_o |-> (disp_o == $past(count_i))); // R4

    AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IDLE) |-> !fire); // R3
endmodule

// File: tb/dfilt_update_filter_tb.sv
module dfilt_update_filter_tb_top;
    localparam int DATA_W = 16;
    localparam int CONF_W = 4;

    typedef struct packed {
        logic [DATA_W-1:0] disp;
        logic              load;
        logic [3:0]        req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe_i = 1'b0;
    logic [DATA_W-1:0] count_i = '0;
    logic [CONF_W-1:0] confirm_n_i = CONF_W'(3);
    logic [DATA_W-1:0] disp_o;
    logic              disp_load_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t q[$];

    // Reference state built from the requirements.
    logic [DATA_W-1:0] m_disp;
    int                m_cnt;
    bit                m_primed;

    always #10 clk = ~clk;

    dfilt_update_filter #(.DATA_W(DATA_W), .CONF_W(CONF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .count_i(count_i),
        .confirm_n_i(confirm_n_i), .disp_o(disp_o), .disp_load_o(disp_load_o)
    );

    task automatic check(input bit ok, input int req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per cycle once the result is registered.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(disp_o == e.disp, int'(e.req), int'(disp_o), int'(e.disp));
            check(disp_load_o == e.load, int'(e.req), int'(disp_load_o), int'(e.load));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        strobe_i = 1'b0;
        repeat (3) @(negedge clk);
        check(disp_o == '0, 1, int'(disp_o), 0);              // R1 during reset
        check(disp_load_o == 1'b0, 1, int'(disp_load_o), 0);  // R1
        rst_n = 1'b1;
        m_disp = '0; m_cnt = 0; m_primed = 1'b0;
        @(negedge clk);
        check(disp_o == '0, 1, int'(disp_o), 0);              // R1 after reset
        check(disp_load_o == 1'b0, 1, int'(disp_load_o), 0);  // R1
    endtask

    // Driver: one strobe carrying value v; expected result queued at the edge.
    task automatic measure(input logic [DATA_W-1:0] v, input int req);
        exp_t e;
        strobe_i = 1'b1;
        count_i  = v;
        e.load   = 1'b0;
        if (!m_primed) begin
            m_disp = v; m_primed = 1'b1; m_cnt = 0; e.load = 1'b1;
        end else if (v == m_disp) begin
            m_cnt = 0;
        end else begin
            m_cnt++;
            if (m_cnt >= int'(confirm_n_i)) begin
                m_disp = v; m_cnt = 0; e.load = 1'b1;
            end
        end
        e.disp = m_disp;
        e.req  = 4'(req);
        @(posedge clk);
        q.push_back(e);
        @(negedge clk);
        strobe_i = 1'b0;
    endtask

    // Idle cycles with a moving count and no strobe: nothing may change.
    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            exp_t e;
            count_i = count_i + 16'd7;
            e.disp = m_disp; e.load = 1'b0; e.req = 4'd3;
            @(posedge clk);
            q.push_back(e);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R0: watchdog expired actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle(3);                                   // R3
        measure(16'd1000, 2);                      // R2 first load
        measure(16'd1000, 5);                      // R5 match
        idle(2);                                   // R3
        for (int i = 0; i < 6; i++) begin          // R6 alternating jitter
            measure(16'd1001, 6);
            measure(16'd1000, 6);
        end
        measure(16'd1001, 4);                      // R4 three in a row
        measure(16'd1001, 4);
        measure(16'd1001, 4);
        measure(16'd1005, 5);
        measure(16'd1006, 5);
        measure(16'd1001, 5);                      // R5 match clears
        measure(16'd1005, 4);                      // R4 differing values
        measure(16'd1006, 4);
        measure(16'd1007, 4);
        measure(16'd1010, 8);                      // R8 full run again
        measure(16'd1010, 8);
        measure(16'd1010, 8);
        confirm_n_i = CONF_W'(1);
        measure(16'd2000, 7);                      // R7 threshold one
        confirm_n_i = CONF_W'(0);
        measure(16'd3000, 7);                      // R7 threshold zero
        confirm_n_i = CONF_W'(4);
        measure(16'd3001, 9);
        measure(16'd3002, 9);
        measure(16'd3003, 9);
        confirm_n_i = CONF_W'(2);
        measure(16'd3004, 9);                      // R9 lowered threshold
        idle(2);
        do_reset();
        confirm_n_i = CONF_W'(3);
        measure(16'd0, 2);                         // R2 equal value still loads
        measure(16'd1, 6);
        measure(16'd0, 6);
        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule